// File: doc/BRIEF.md
# Read-Hit Refetch Request Filter

This block sits beside a first-level data cache and turns read hits into refetch requests for a refetch engine that reloads lines from the error-protected next level. Each accepted read hit offers two candidate blocks: the block that was just read and its spatial successor. The successor is reached by stepping the set index by one and carrying into the tag when the index wraps. The successor is offered only when the cache reports that it is resident.

To keep extra next-level bus traffic low, each candidate is checked against a small table of recent refetches. A block whose refetch is still outstanding is not asked for again. A block whose refetch finished fewer than K cycles ago is not asked for again either. K is an input, intended to be 0, 100 or 200. The table is keyed by block address, reuses idle or expired entries first, and otherwise replaces the least recently claimed entry.

Surviving candidates wait in a two-slot output stage and leave under a valid/ready handshake, current block first. A hit that arrives while that stage cannot take a full pair is discarded without leaving any trace in the table.

Top module: `refetch_filter`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, `req_valid` is low.
- R2: A read hit on block B that arrives while the output stage is empty, with B neither outstanding nor recently completed, presents `req_valid` with `req_blk` = B in the next cycle. Without a hit, no request appears.
- R3: When `nbr_present` is high with the hit, the successor block is presented right after the current one, as a second request. The block address is {tag, set}, with the set index in the low SET_W bits. The successor has the same tag and set index + 1.
- R4: When the set index of the hit is all ones, the successor has set index 0 and tag + 1.
- R5: When `nbr_present` is low, only the current block is requested.
- R6: A block is outstanding from the cycle its candidate is accepted until a completion for it is sampled. A candidate for an outstanding block is dropped, including when the completion arrives in the same cycle as the hit.
- R7: A completion for block B is sampled in cycle c. A hit on B in cycle c+a is dropped when a < K and is issued when a >= K.
- R8: With K = 0, a hit in the cycle after a completion for the same block is issued, so only outstanding duplicates are suppressed.
- R9: A hit is discarded whole, and leaves no table state, when the presented request is not accepted in that cycle or when a second request waits behind it.
- R10: While `req_valid` is high and `req_ready` is low, `req_valid` stays high and `req_blk` is unchanged in the next cycle.
- R11: The table holds 8 blocks. When no entry is free or expired, the least recently claimed entry is replaced, and that block loses its suppression.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| win_cycles | input | WIN_W | Post-completion suppression window K in cycles |
| hit_valid | input | 1 | L1 read hit strobe |
| hit_blk | input | BLK_W | Block address {tag, set} of the read hit |
| nbr_present | input | 1 | Successor block is resident, valid with hit_valid |
| done_valid | input | 1 | Refetch completion notice |
| done_blk | input | BLK_W | Block address of the completed refetch |
| req_valid | output | 1 | Refetch request valid |
| req_ready | input | 1 | Refetch engine accepts the request |
| req_blk | output | BLK_W | Block address to refetch |

## Verification
The two functions that can meet in one cycle are the retirement of a refetch and a new read hit on the same block. The completion clears the outstanding mark, while the hit checks that same mark. The bench drives `done_valid` and `hit_valid` for one block in the same cycle and expects no request, because suppression is judged on the table as it stood before the completion. A hit on the following cycle with K = 0 must then be issued. A second collision, between a hit and a full output stage being drained, is provoked by hitting in the cycle after a pair was queued, and is judged by that hit never producing a request.

// File: rtl/rf_pkg.sv
package rf_pkg;

    // Occupancy of the two-slot output stage
    typedef enum logic [1:0] {
        OCC_EMPTY = 2'd0,
        OCC_ONE   = 2'd1,
        OCC_TWO   = 2'd2
    } occ_e;

endpackage

// File: rtl/rf_table.sv
// Tracking table: outstanding and recently completed refetches with
// per-entry age since completion and a rank used for replacement.
module rf_table #(
    parameter int unsigned BLK_W   = 12,
    parameter int unsigned WIN_W   = 8,
    parameter int unsigned ENTRIES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIN_W-1:0] win,
    input  logic             take,
    input  logic [BLK_W-1:0] cur_blk,
    input  logic [BLK_W-1:0] nxt_blk,
    input  logic             nxt_ok,
    input  logic             done_valid,
    input  logic [BLK_W-1:0] done_blk,
    output logic             issue_cur,
    output logic             issue_nxt
);

    localparam int unsigned RANK_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic              vld;
        logic              busy;
        logic [BLK_W-1:0]  blk;
        logic [WIN_W-1:0]  age;
        logic [RANK_W-1:0] rank;
    } ent_t;

    typedef ent_t [ENTRIES-1:0] tbl_t;

    tbl_t tbl_d, tbl_q;

    // Claim an entry for block b: reuse a matching entry, else the first
    // free or expired one, else the least recently claimed one.
    function automatic tbl_t claim(tbl_t t, logic [BLK_W-1:0] b, logic [WIN_W-1:0] k);
        tbl_t              r;
        logic [RANK_W-1:0] idx;
        logic [RANK_W-1:0] oldest;
        logic              found;
        r      = t;
        idx    = '0;
        oldest = '0;
        found  = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!found && t[i].vld && t[i].blk == b) begin
                idx   = RANK_W'(i);
                found = 1'b1;
            end
        end
        for (int i = 0; i < ENTRIES; i++) begin
            if (!found && (!t[i].vld || (!t[i].busy && t[i].age >= k))) begin
                idx   = RANK_W'(i);
                found = 1'b1;
            end
        end
        for (int i = 0; i < ENTRIES; i++) begin
            if (t[i].rank == RANK_W'(ENTRIES - 1)) begin
                oldest = RANK_W'(i);
            end
        end
        if (!found) begin
            idx = oldest;
        end
        for (int i = 0; i < ENTRIES; i++) begin
            if (t[i].rank < t[idx].rank) begin
                r[i].rank = t[i].rank + 1'b1;
            end
        end
        r[idx].rank = '0;
        r[idx].vld  = 1'b1;
        r[idx].busy = 1'b1;
        r[idx].blk  = b;
        r[idx].age  = '0;
        return r;
    endfunction

    always_comb begin
        logic hold_cur;
        logic hold_nxt;
        hold_cur = 1'b0;
        hold_nxt = 1'b0;
        // Suppression is judged on the table as registered
        for (int i = 0; i < ENTRIES; i++) begin
            if (tbl_q[i].vld && (tbl_q[i].busy || tbl_q[i].age < win)) begin
                if (tbl_q[i].blk == cur_blk) hold_cur = 1'b1;
                if (tbl_q[i].blk == nxt_blk) hold_nxt = 1'b1;
            end
        end
        issue_cur = take && !hold_cur;
        issue_nxt = take && nxt_ok && !hold_nxt;

        tbl_d = tbl_q;
        for (int i = 0; i < ENTRIES; i++) begin
            if (tbl_d[i].vld && !tbl_d[i].busy && tbl_d[i].age != '1) begin
                tbl_d[i].age = tbl_d[i].age + 1'b1;
            end
            if (done_valid && tbl_d[i].vld && tbl_d[i].blk == done_blk) begin
                tbl_d[i].busy = 1'b0;
                tbl_d[i].age  = WIN_W'(1);
            end
        end
        if (issue_cur) tbl_d = claim(tbl_d, cur_blk, win);
        if (issue_nxt) tbl_d = claim(tbl_d, nxt_blk, win);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                tbl_q[i].vld  <= 1'b0;
                tbl_q[i].busy <= 1'b0;
                tbl_q[i].blk  <= '0;
                tbl_q[i].age  <= '0;
                tbl_q[i].rank <= RANK_W'(i);
            end
        end else begin
            tbl_q <= tbl_d;
        end
    end

endmodule

// File: rtl/rf_outbuf.sv
// Two-slot output stage; takes a pair only when it drains empty this cycle.
module rf_outbuf #(
    parameter int unsigned BLK_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_a,
    input  logic [BLK_W-1:0] blk_a,
    input  logic             push_b,
    input  logic [BLK_W-1:0] blk_b,
    output logic             room,
    output logic             req_valid,
    input  logic             req_ready,
    output logic [BLK_W-1:0] req_blk
);

    import rf_pkg::*;

    typedef struct packed {
        occ_e             occ;
        logic [BLK_W-1:0] s0;
        logic [BLK_W-1:0] s1;
    } ob_t;

    ob_t st_d, st_q;

    assign req_valid = (st_q.occ != OCC_EMPTY);
    assign req_blk   = st_q.s0;
    assign room      = (st_q.occ == OCC_EMPTY) || (st_q.occ == OCC_ONE && req_ready);

    always_comb begin
        st_d = st_q;
        if (req_valid && req_ready) begin
            if (st_q.occ == OCC_TWO) begin
                st_d.s0  = st_q.s1;
                st_d.occ = OCC_ONE;
            end else begin
                st_d.occ = OCC_EMPTY;
            end
        end
        if (push_a && push_b) begin
            st_d.s0  = blk_a;
            st_d.s1  = blk_b;
            st_d.occ = OCC_TWO;
        end else if (push_a) begin
            st_d.s0  = blk_a;
            st_d.occ = OCC_ONE;
        end else if (push_b) begin
            st_d.s0  = blk_b;
            st_d.occ = OCC_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.occ <= OCC_EMPTY;
            st_q.s0  <= '0;
            st_q.s1  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/refetch_filter.sv
module refetch_filter #(
    parameter int unsigned BLK_W   = 12,
    parameter int unsigned SET_W   = 5,
    parameter int unsigned WIN_W   = 8,
    parameter int unsigned ENTRIES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIN_W-1:0] win_cycles,
    input  logic             hit_valid,
    input  logic [BLK_W-1:0] hit_blk,
    input  logic             nbr_present,
    input  logic             done_valid,
    input  logic [BLK_W-1:0] done_blk,
    output logic             req_valid,
    input  logic             req_ready,
    output logic [BLK_W-1:0] req_blk
);

    localparam int unsigned TAG_W = BLK_W - SET_W;

    logic [TAG_W-1:0] tag_nx;
    logic [SET_W-1:0] set_nx;
    logic [BLK_W-1:0] nxt_blk;
    logic             room;
    logic             take;
    logic             issue_cur;
    logic             issue_nxt;

    // Successor: next set index, tag carries when the index wraps
    assign set_nx  = hit_blk[SET_W-1:0] + 1'b1;
    assign tag_nx  = hit_blk[BLK_W-1:SET_W] + TAG_W'(&hit_blk[SET_W-1:0]);
    assign nxt_blk = {tag_nx, set_nx};
    assign take    = hit_valid && room;

    rf_table #(
        .BLK_W   (BLK_W),
        .WIN_W   (WIN_W),
        .ENTRIES (ENTRIES)
    ) table_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .win        (win_cycles),
        .take       (take),
        .cur_blk    (hit_blk),
        .nxt_blk    (nxt_blk),
        .nxt_ok     (nbr_present),
        .done_valid (done_valid),
        .done_blk   (done_blk),
        .issue_cur  (issue_cur),
        .issue_nxt  (issue_nxt)
    );

    rf_outbuf #(
        .BLK_W (BLK_W)
    ) outbuf_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_a    (issue_cur),
        .blk_a     (hit_blk),
        .push_b    (issue_nxt),
        .blk_b     (nxt_blk),
        .room      (room),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_blk   (req_blk)
    );

endmodule

// File: rtl/refetch_filter_chk.sv
module refetch_filter_chk #(
    parameter int unsigned BLK_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hit_valid,
    input logic [BLK_W-1:0] hit_blk,
    input logic             req_valid,
    input logic             req_ready,
    input logic [BLK_W-1:0] req_blk
);

    // R1: nothing is presented straight out of reset
    p_quiet_reset_r1: assert property (@(posedge clk)
        !rst_n |=> !req_valid);

    // R2: a request never appears without a hit
    p_no_spontaneous_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_valid && !req_valid) |=> !req_valid);

    // R3: a fresh request is the hit block or its successor
    p_origin_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && !req_valid) |=>
        (!req_valid || req_blk == $past(hit_blk) || req_blk == $past(hit_blk) + BLK_W'(1)));

    // R10: a stalled request holds its value
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_blk)));

    // R9: a hit during a stall does not displace the presented request
    p_stall_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready && hit_valid) |=> (req_blk == $past(req_blk)));

endmodule

bind refetch_filter refetch_filter_chk #(.BLK_W(BLK_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit_valid (hit_valid),
    .hit_blk   (hit_blk),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_blk   (req_blk)
);

// File: tb/refetch_filter_tb_top.sv
`timescale 1ns/1ps
module refetch_filter_tb_top;

    localparam int unsigned BLK_W = 12;
    localparam int unsigned SET_W = 5;
    localparam int unsigned WIN_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [WIN_W-1:0] win_cycles = '0;
    logic             hit_valid = 1'b0;
    logic [BLK_W-1:0] hit_blk = '0;
    logic             nbr_present = 1'b0;
    logic             done_valid = 1'b0;
    logic [BLK_W-1:0] done_blk = '0;
    logic             req_valid;
    logic             req_ready = 1'b1;
    logic [BLK_W-1:0] req_blk;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    refetch_filter #(
        .BLK_W (BLK_W),
        .SET_W (SET_W),
        .WIN_W (WIN_W)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .win_cycles  (win_cycles),
        .hit_valid   (hit_valid),
        .hit_blk     (hit_blk),
        .nbr_present (nbr_present),
        .done_valid  (done_valid),
        .done_blk    (done_blk),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_blk     (req_blk)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_ready = 1'b1;
        idle(2);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Hit occupies one cycle; returns at the negedge where its result shows
    task automatic hit(input logic [BLK_W-1:0] b, input bit nbr);
        hit_valid   = 1'b1;
        hit_blk     = b;
        nbr_present = nbr;
        @(negedge clk);
        hit_valid   = 1'b0;
        nbr_present = 1'b0;
    endtask

    task automatic done(input logic [BLK_W-1:0] b);
        done_valid = 1'b1;
        done_blk   = b;
        @(negedge clk);
        done_valid = 1'b0;
    endtask

    // Check the presented request, then let one cycle pass (ready high pops it)
    task automatic expect_req(input logic [BLK_W-1:0] b, input string rq);
        chk(req_valid === 1'b1 && req_blk === b, rq, {req_valid, req_blk}, {1'b1, b});
        @(negedge clk);
    endtask

    task automatic expect_none(input string rq);
        chk(req_valid === 1'b0, rq, req_valid, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        idle(2);
        chk(req_valid === 1'b0, "R1 in reset", req_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_valid === 1'b0, "R1 after release", req_valid, 0);
    endtask

    task automatic t_single();
        do_reset();
        win_cycles = 8'd0;
        idle(2);
        expect_none("R2 no hit no request");
        hit(12'h045, 1'b0);
        expect_req(12'h045, "R2 current block");
        expect_none("R5 no successor without presence");
    endtask

    task automatic t_pair();
        do_reset();
        hit(12'h0A3, 1'b1);
        expect_req(12'h0A3, "R3 current first");
        expect_req(12'h0A4, "R3 successor second");
        expect_none("R3 only two requests");
    endtask

    task automatic t_wrap();
        do_reset();
        hit(12'h07F, 1'b1);              // tag 3, set 31
        expect_req(12'h07F, "R4 current");
        expect_req(12'h080, "R4 successor tag+1 set 0");
        expect_none("R4 done");
    endtask

    task automatic t_inflight();
        do_reset();
        win_cycles = 8'd0;
        hit(12'h200, 1'b0);
        expect_req(12'h200, "R6 first issue");
        hit(12'h200, 1'b0);
        expect_none("R6 outstanding duplicate dropped");
        // completion and hit in the same cycle
        done_valid = 1'b1;
        done_blk   = 12'h200;
        hit(12'h200, 1'b0);
        done_valid = 1'b0;
        expect_none("R6 same-cycle completion still suppresses");
        hit(12'h200, 1'b0);
        expect_req(12'h200, "R8 K=0 issue right after completion");
    endtask

    task automatic t_window();
        do_reset();
        win_cycles = 8'd10;
        hit(12'h300, 1'b0);
        expect_req(12'h300, "R7 first issue");
        done(12'h300);                   // sampled in cycle c
        idle(8);
        hit(12'h300, 1'b0);              // cycle c+9
        expect_none("R7 dropped at a=9 < K=10");
        hit(12'h300, 1'b0);              // cycle c+10
        expect_req(12'h300, "R7 issued at a=10");
    endtask

    task automatic t_stall();
        do_reset();
        win_cycles = 8'd0;
        req_ready = 1'b0;
        hit(12'h150, 1'b1);
        chk(req_valid === 1'b1 && req_blk === 12'h150, "R10 presented", req_blk, 12'h150);
        hit(12'h400, 1'b0);              // arrives during stall
        idle(3);
        chk(req_valid === 1'b1 && req_blk === 12'h150, "R10 held under stall", req_blk, 12'h150);
        req_ready = 1'b1;
        expect_req(12'h150, "R9 queued current");
        expect_req(12'h151, "R9 queued successor");
        expect_none("R9 stalled hit discarded");
        hit(12'h400, 1'b0);
        expect_req(12'h400, "R9 stalled hit left no table state");
        // hit while a second request waits behind the presented one
        hit(12'h500, 1'b1);
        hit(12'h600, 1'b0);
        expect_req(12'h501, "R9 pair drains");
        expect_none("R9 hit behind pair discarded");
        hit(12'h600, 1'b0);
        expect_req(12'h600, "R9 dropped hit later issued");
    endtask

    task automatic t_lru();
        do_reset();
        win_cycles = 8'd200;
        for (int i = 0; i < 8; i++) begin
            hit(12'h700 + 12'(2 * i), 1'b0);
            expect_req(12'h700 + 12'(2 * i), "R11 fill");
            done(12'h700 + 12'(2 * i));
        end
        hit(12'h710, 1'b0);
        expect_req(12'h710, "R11 ninth block issued");
        hit(12'h704, 1'b0);
        expect_none("R11 retained block still suppressed");
        hit(12'h700, 1'b0);
        expect_req(12'h700, "R11 oldest block evicted");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog all actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_single();
        t_pair();
        t_wrap();
        t_inflight();
        t_window();
        t_stall();
        t_lru();
        idle(2);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule